// File: doc/BRIEF.md
# Three-Wire Addressed Programming Register

This block receives configuration words over a one-way serial link made of a data line, a serial clock and an active-low enable. While the enable line is held low, each rising edge of the serial clock shifts one data bit into a 21-bit shift register. Only the newest 21 bits are kept, and the number of clock pulses is never counted. When the enable line returns high, the four bits received last are read as an address. If that address is one of four selected codes, the 17 bits received before it are copied into the matching output word. A single-cycle strobe marks which word was written.

The three serial inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and serial clock edges are detected on the synchronized copy. Each serial line level must therefore stay steady for at least three system clock cycles. No other input gates the interface, so it keeps accepting and latching data whatever state the surrounding circuit is in.

Top module: `tri_wire_loader`

## Requirements
- R1: Serial clock rising edges that occur while `ser_en_n` is high do not shift data and do not alter the shift register contents.
- R2: Only the last 21 bits shifted during a low period of `ser_en_n` matter; any bits received before those are discarded without notice.
- R3: Bits arrive most significant first. Of the last 21 bits received, the first 17 form the data word (the first of them is data bit 16). The final 4 bits form the address, and the very last bit is address bit 0.
- R4: One cycle after the synchronized enable is seen rising, the addressed output word takes the data field. In that same cycle exactly one bit of `load_stb` is high, for exactly one cycle, and the bit index matches the word that was written.
- R5: Address codes 0, 1, 2 and 3 (parameters `SEL0`..`SEL3`) select `word0`..`word3`. Any other address produces no strobe and leaves all four words unchanged.
- R6: If fewer than 21 bits were shifted since the previous release of enable, the older bits still in the shift register are used unchanged. A release with no shifts at all reloads the previous frame.
- R7: While `rst_n` is low, all four words and `load_stb` are zero and the shift register is cleared.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_en_n | input | 1 | Active-low frame enable; its rising edge loads |
| word0 | output | 17 | Word selected by address `SEL0` |
| word1 | output | 17 | Word selected by address `SEL1` |
| word2 | output | 17 | Word selected by address `SEL2` |
| word3 | output | 17 | Word selected by address `SEL3` |
| load_stb | output | 4 | One-cycle strobe, bit i marks a write to word i |

## Verification
The bench sends frames that are longer than 21 bits with leading junk. A design that counted pulses or kept the oldest bits would then load the wrong word or the wrong address. It pulses the serial clock with enable high and then releases an empty frame; a design that shifted on those edges would reload a different address or different data. It also sends an unused address code and a four-bit frame that must reuse older register contents, which catches decoders that write on any code and designs that clear the register between frames.

// File: rtl/tri_wire_loader.sv
module tri_wire_loader #(
  parameter int DATA_W = 17,
  parameter int ADDR_W = 4,
  parameter int SYNC = 2,
  parameter logic [ADDR_W-1:0] SEL0 = 0,
  parameter logic [ADDR_W-1:0] SEL1 = 1,
  parameter logic [ADDR_W-1:0] SEL2 = 2,
  parameter logic [ADDR_W-1:0] SEL3 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_en_n,
  output logic [DATA_W-1:0] word0,
  output logic [DATA_W-1:0] word1,
  output logic [DATA_W-1:0] word2,
  output logic [DATA_W-1:0] word3,
  output logic [3:0]        load_stb
);
  localparam int FRAME_W = DATA_W + ADDR_W;

  logic [SYNC-1:0]    clk_sy, dat_sy, en_sy;
  logic               clk_prev, en_prev;
  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_sy   <= '1;
      dat_sy   <= '0;
      en_sy    <= '1;
      clk_prev <= 1'b1;
      en_prev  <= 1'b1;
    end else begin
      clk_sy   <= {clk_sy[SYNC-2:0], ser_clk};
      dat_sy   <= {dat_sy[SYNC-2:0], ser_dat};
      en_sy    <= {en_sy[SYNC-2:0], ser_en_n};
      clk_prev <= clk_sy[SYNC-1];
      en_prev  <= en_sy[SYNC-1];
    end

  wire en_now   = en_sy[SYNC-1];
  wire en_rise  = en_now & ~en_prev;
  wire shift_go = clk_sy[SYNC-1] & ~clk_prev & ~en_now;

  wire [ADDR_W-1:0] addr  = shreg[ADDR_W-1:0];
  wire [DATA_W-1:0] field = shreg[FRAME_W-1:ADDR_W];
  wire [3:0] hit = {addr == SEL3, addr == SEL2, addr == SEL1, addr == SEL0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      shreg <= '0;
    else if (shift_go)
      shreg <= {shreg[FRAME_W-2:0], dat_sy[SYNC-1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      load_stb <= '0;
      word0    <= '0;
      word1    <= '0;
      word2    <= '0;
      word3    <= '0;
    end else begin
      load_stb <= en_rise ? hit : 4'b0;
      if (en_rise && hit[0]) word0 <= field;
      if (en_rise && hit[1]) word1 <= field;
      if (en_rise && hit[2]) word2 <= field;
      if (en_rise && hit[3]) word3 <= field;
    end
endmodule

// File: rtl/tri_wire_loader_chk.sv
module tri_wire_loader_chk #(
  parameter int DATA_W = 17,
  parameter int ADDR_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     en_now,
  input logic                     en_rise,
  input logic [DATA_W+ADDR_W-1:0] shreg,
  input logic [DATA_W-1:0]        word0,
  input logic [DATA_W-1:0]        word1,
  input logic [DATA_W-1:0]        word2,
  input logic [DATA_W-1:0]        word3,
  input logic [3:0]               load_stb
);
  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_stb));
  a_r4_strobe_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb != 4'b0) |-> $past(en_rise));
  a_r4_word0_data: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb[0] |-> word0 == $past(shreg[DATA_W+ADDR_W-1:ADDR_W]));
  a_r5_word0_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_stb[0] |-> $stable(word0));
  a_r5_word1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_stb[1] |-> $stable(word1));
  a_r5_word2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_stb[2] |-> $stable(word2));
  a_r5_word3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_stb[3] |-> $stable(word3));
  a_r1_no_shift_when_high: assert property (@(posedge clk) disable iff (!rst_n)
    en_now |=> $stable(shreg));
endmodule

bind tri_wire_loader tri_wire_loader_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_now(en_now), .en_rise(en_rise), .shreg(shreg),
  .word0(word0), .word1(word1), .word2(word2), .word3(word3), .load_stb(load_stb)
);

// File: tb/sim_tri_wire_loader.sv
module sim_tri_wire_loader;
  logic clk = 0, rst_n = 0, ser_clk = 1, ser_dat = 0, ser_en_n = 1;
  logic [16:0] word0, word1, word2, word3;
  logic [3:0]  load_stb;
  int errors = 0, checks = 0;
  logic [20:0] sh_m = '0;
  logic [16:0] mw [4];
  int          qi [$];
  logic [16:0] qw [$];

  always #2 clk = ~clk;

  tri_wire_loader u0 (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_en_n(ser_en_n), .word0(word0), .word1(word1), .word2(word2), .word3(word3),
    .load_stb(load_stb));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b, input logic with_en);
    ser_dat = b; ser_clk = 0; wait_cyc(4);
    ser_clk = 1; wait_cyc(4);
    if (with_en) sh_m = {sh_m[19:0], b};
  endtask

  task automatic frame(input logic [31:0] bits, input int n, input string req);
    ser_en_n = 0; wait_cyc(4);
    for (int i = n - 1; i >= 0; i--) shift_bit(bits[i], 1'b1);
    ser_en_n = 1;
    if (sh_m[3:0] < 4) begin
      qi.push_back(int'(sh_m[3:0]));
      qw.push_back(sh_m[20:4]);
      mw[sh_m[3:0]] = sh_m[20:4];
    end
    wait_cyc(12);
    chk({req, " word0"}, 32'(word0), 32'(mw[0]));
    chk({req, " word1"}, 32'(word1), 32'(mw[1]));
    chk({req, " word2"}, 32'(word2), 32'(mw[2]));
    chk({req, " word3"}, 32'(word3), 32'(mw[3]));
    chk({req, " strobe queue drained"}, 32'(qi.size()), 32'd0);
  endtask

  always @(negedge clk)
    if (rst_n && load_stb != 4'b0) begin
      if (qi.size() == 0) begin
        chk("R5 unexpected strobe", 32'(load_stb), 32'd0);
      end else begin
        int i;
        logic [16:0] w;
        i = qi.pop_front();
        w = qw.pop_front();
        chk("R4 strobe index", 32'(load_stb), 32'(1 << i));
        case (i)
          0: chk("R4 strobe data w0", 32'(word0), 32'(w));
          1: chk("R4 strobe data w1", 32'(word1), 32'(w));
          2: chk("R4 strobe data w2", 32'(word2), 32'(w));
          default: chk("R4 strobe data w3", 32'(word3), 32'(w));
        endcase
      end
    end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) mw[k] = '0;
    wait_cyc(5);
    chk("R7 reset word0", 32'(word0), 0);
    chk("R7 reset stb", 32'(load_stb), 0);
    rst_n = 1; wait_cyc(5);
    chk("R7 after reset word3", 32'(word3), 0);

    frame({11'b0, 17'h1A5C3, 4'd0}, 21, "R3 R4 R5 addr0");
    frame({11'b0, 17'h0F0F1, 4'd1}, 21, "R3 R4 R5 addr1");
    frame({11'b0, 17'h10001, 4'd2}, 21, "R3 R4 R5 addr2");
    frame({11'b0, 17'h1FFFF, 4'd3}, 21, "R3 R4 R5 addr3");
    frame({11'b0, 17'h05555, 4'd9}, 21, "R5 unused addr 9");
    frame({11'b0, 17'h0AAAA, 4'd15}, 21, "R5 unused addr 15");
    frame({4'b1011, 3'b0, 17'h12345, 4'd2}, 25, "R2 leading junk");
    frame({1'b1, 10'h3FF, 17'h00777, 4'd1}, 32, "R2 eleven leading ones");

    frame({11'b0, 17'h0BEEF, 4'd1}, 21, "R3 setup");
    for (int k = 0; k < 5; k++) shift_bit(1'b1, 1'b0);
    wait_cyc(8);
    chk("R1 no strobe on high-enable edges", 32'(qi.size()), 0);
    frame(32'd0, 0, "R1 R6 empty frame reload");

    frame({28'd0, 4'd3}, 4, "R6 short frame reuse");
    frame({24'd0, 8'hA2}, 8, "R6 eight-bit frame");

    rst_n = 0; wait_cyc(3);
    chk("R7 mid reset word1", 32'(word1), 0);
    chk("R7 mid reset word2", 32'(word2), 0);
    rst_n = 1; wait_cyc(3);
    sh_m = '0;
    for (int k = 0; k < 4; k++) mw[k] = '0;
    frame({28'd0, 4'd0}, 4, "R7 R6 cleared register");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule